// File: doc/BRIEF.md
# Pulse-Position Command Frame Decoder

This block turns the reader-to-card half of a contactless link back into bytes. Each clock cycle may bring one window of four envelope samples. A low sample means the carrier dropped. The decoder waits for a quiet line, locks onto the sample lane where the first drop shows, and from then on reads one lane value per window. Two windows make one slot: a first half and a second half.

The opening four-slot group fixes the coding. A drop in slot 3 selects four-slot groups that carry two bits each. A drop in slot 4 selects 256-slot groups that carry a whole byte. Received bytes go into a small buffer, with an odd-parity bit per byte collected alongside. A drop in the first half of a group's first slot ends the frame. A non-empty frame is reported with a one-cycle pulse, and the decoder then stays parked until the surrounding logic restarts it. CRC checking and command interpretation are left to the consumer, which reads the buffer through a combinational read port.

Top module: `ppd_cmd_decoder`

## Requirements
- R1: A frame can begin only on a valid window containing a drop that follows at least 8 consecutive valid all-high windows (`in_win == 4'hF`). A drop window after fewer high windows starts nothing and restarts the count.
- R2: `in_win[3]` is the earliest sample in time. At frame start, the lane of the earliest low sample becomes the sync lane, and every later half-slot decision reads only that lane. The start window itself is the first half of slot 1.
- R3: A slot's drop position is its 1-based index within the group, and only second-half drops count. At the end of the opening four-slot group, position 3 gives 2-bit mode (`wide_mode=0`) and position 4 gives byte mode (`wide_mode=1`). Either one raises `synced`. Any other position drops `synced`.
- R4: In 2-bit mode each four-slot group yields (position-1). Pairs arrive least significant first: the first pair becomes bits 1:0 of the byte. After four pairs the byte is stored and `byte_count` rises by one.
- R5: In byte mode each 256-slot group yields one byte equal to (position-1), so position 1 gives 0x00 and position 256 gives 0xFF.
- R6: Three events inside a frame each clear `synced` without a frame report: a second drop in one group, a group without any drop, or a first-half drop in any slot but the first of a group.
- R7: A first-half drop in the first slot of a group, with at least one byte stored, raises `frame_done` for exactly one cycle while `byte_count` holds the total. `synced` is then low, and all further windows are ignored until `restart`.
- R8: The same end condition with no stored byte stores 0xF0 at address 0, sets `byte_count` to 1, shifts in its parity bit, gives no `frame_done`, and returns to searching.
- R9: Each stored byte shifts its odd-parity bit (set when the byte has an even number of ones) into `parity_bits` at bit 0. Frame start clears `parity_bits`.
- R10: Once 32 bytes are stored, further bytes are dropped: `byte_count` stays at 32, `parity_bits` stops shifting, and `overflow` is set.
- R11: `restart` clears `synced`, `byte_count`, `parity_bits`, `overflow`, `wide_mode` and the high-window count. A window presented in the same cycle is discarded.
- R12: After reset, `synced`, `wide_mode`, `frame_done`, `overflow`, `byte_count` and `parity_bits` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Clears decoder state and leaves the parked state |
| in_valid | input | 1 | A sample window is present this cycle |
| in_win | input | 4 | Envelope samples, bit 3 earliest, 0 = carrier drop |
| rd_addr | input | 5 | Byte buffer read address |
| rd_data | output | 8 | Byte at `rd_addr` (combinational) |
| synced | output | 1 | Frame in progress |
| wide_mode | output | 1 | 1 = 256-slot byte coding, 0 = 4-slot pair coding |
| frame_done | output | 1 | One-cycle end-of-frame report |
| byte_count | output | 6 | Bytes stored in the current frame |
| parity_bits | output | 32 | Odd-parity bits, newest at bit 0 |
| overflow | output | 1 | A byte was dropped because the buffer was full |

## Verification
Two things can fall in the same cycle: a `restart` and a valid drop window arriving after a full qualifying run of high windows. On its own, that window would open a frame. The bench sets up exactly this case and then sends a drop window right away. It judges the outcome by `synced` staying low both times, which shows that the window was discarded and that the high count was cleared. A behavioural model built from queues and integers follows every other cycle, including the cycle where the 33rd byte meets a full buffer and sets `overflow` instead of being stored.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

    localparam int BYTE_W = 8;
    localparam int SLOT_W = BYTE_W + 1;
    localparam logic [BYTE_W-1:0] EMPTY_MARK = 8'hF0;

    typedef enum logic [1:0] {
        PH_SEARCH,
        PH_OPEN,
        PH_DATA,
        PH_PARK
    } phase_t;

    typedef struct packed {
        logic              wide;
        logic              second;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] pos;
    } slot_ctx_t;

    function automatic logic odd_par(input logic [BYTE_W-1:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/ppd_sync_front.sv
module ppd_sync_front #(
    parameter int LANES    = 4,
    parameter int IDLE_MIN = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic                     in_valid,
    input  logic [LANES-1:0]         in_win,
    input  logic                     searching,
    output logic                     start,
    output logic                     line_bit
);

    localparam int CNT_W  = $clog2(IDLE_MIN + 1);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [CNT_W-1:0]  high_cnt;
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] lane_pick;
    logic              any_drop;

    assign any_drop = ~&in_win;
    assign start    = searching && in_valid && any_drop
                      && (high_cnt == CNT_W'(IDLE_MIN));
    assign line_bit = in_win[lane_q];

    // highest index wins: later iterations override earlier ones
    always_comb begin
        lane_pick = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!in_win[i]) lane_pick = LANE_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            high_cnt <= '0;
            lane_q   <= '0;
        end else if (!searching) begin
            high_cnt <= '0;
        end else if (in_valid) begin
            if (!any_drop) begin
                if (high_cnt != CNT_W'(IDLE_MIN)) high_cnt <= high_cnt + 1'b1;
            end else begin
                high_cnt <= '0;
            end
            if (start) lane_q <= lane_pick;
        end
    end

endmodule

// File: rtl/ppd_byte_store.sv
module ppd_byte_store
    import ppd_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [DEPTH-1:0]           parity,
    output logic                       overflow
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              full;

    assign full    = (count == CNT_W'(DEPTH));
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count    <= '0;
            parity   <= '0;
            overflow <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                overflow <= 1'b1;
            end else begin
                count  <= count + 1'b1;
                parity <= {parity[DEPTH-2:0], odd_par(wr_data)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clear && wr_en && !full) mem[count[ADDR_W-1:0]] <= wr_data;
    end

endmodule

// File: rtl/ppd_cmd_decoder.sv
module ppd_cmd_decoder
    import ppd_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int IDLE_MIN = 8,
    parameter int DEPTH    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       restart,
    input  logic                       in_valid,
    input  logic [LANES-1:0]           in_win,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic                       synced,
    output logic                       wide_mode,
    output logic                       frame_done,
    output logic [$clog2(DEPTH+1)-1:0] byte_count,
    output logic [DEPTH-1:0]           parity_bits,
    output logic                       overflow
);

    localparam int NARROW = 4;
    localparam int WIDE   = 1 << BYTE_W;
    localparam int PAIRS  = BYTE_W / 2;
    localparam int PAIR_W = $clog2(PAIRS);

    phase_t            phase, phase_n;
    slot_ctx_t         ctx, ctx_n;
    logic [BYTE_W-1:0] shreg, shreg_n;
    logic [PAIR_W-1:0] pairs, pairs_n;
    logic              done_n;
    logic              start, line_bit, drop;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [SLOT_W-1:0] slot_next, pos_next, group_len;
    logic              twice;

    ppd_sync_front #(.LANES(LANES), .IDLE_MIN(IDLE_MIN)) u_front (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .in_valid  (in_valid),
        .in_win    (in_win),
        .searching (phase == PH_SEARCH),
        .start     (start),
        .line_bit  (line_bit)
    );

    ppd_byte_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart || start),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .count    (byte_count),
        .parity   (parity_bits),
        .overflow (overflow)
    );

    assign drop      = !line_bit;
    assign slot_next = ctx.slot + 1'b1;
    assign twice     = drop && (ctx.pos != '0);
    assign pos_next  = (drop && ctx.pos == '0) ? slot_next : ctx.pos;
    assign group_len = (phase == PH_DATA && ctx.wide) ? SLOT_W'(WIDE) : SLOT_W'(NARROW);

    always_comb begin
        phase_n = phase;
        ctx_n   = ctx;
        shreg_n = shreg;
        pairs_n = pairs;
        done_n  = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        if (phase == PH_SEARCH) begin
            if (start) begin
                phase_n = PH_OPEN;
                ctx_n   = '{wide: 1'b0, second: 1'b1, slot: '0, pos: '0};
                shreg_n = '0;
                pairs_n = '0;
            end
        end else if (phase != PH_PARK && in_valid) begin
            if (!ctx.second) begin
                ctx_n.second = 1'b1;
                if (drop && phase == PH_DATA) begin
                    if (ctx.slot != '0) begin
                        phase_n = PH_SEARCH;
                    end else if (byte_count != '0) begin
                        phase_n = PH_PARK;
                        done_n  = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_data = EMPTY_MARK;
                        phase_n = PH_SEARCH;
                    end
                end
            end else begin
                ctx_n.second = 1'b0;
                if (twice) begin
                    phase_n = PH_SEARCH;
                end else if (slot_next == group_len) begin
                    ctx_n.slot = '0;
                    ctx_n.pos  = '0;
                    if (phase == PH_OPEN) begin
                        if (pos_next == SLOT_W'(4)) begin
                            phase_n    = PH_DATA;
                            ctx_n.wide = 1'b1;
                        end else if (pos_next == SLOT_W'(3)) begin
                            phase_n    = PH_DATA;
                            ctx_n.wide = 1'b0;
                        end else begin
                            phase_n = PH_SEARCH;
                        end
                    end else if (pos_next == '0) begin
                        phase_n = PH_SEARCH;
                    end else if (ctx.wide) begin
                        wr_en   = 1'b1;
                        wr_data = BYTE_W'(pos_next - 1'b1);
                    end else begin
                        shreg_n = {2'(pos_next - 1'b1), shreg[BYTE_W-1:2]};
                        if (pairs == PAIR_W'(PAIRS - 1)) begin
                            wr_en   = 1'b1;
                            wr_data = shreg_n;
                            shreg_n = '0;
                            pairs_n = '0;
                        end else begin
                            pairs_n = pairs + 1'b1;
                        end
                    end
                end else begin
                    ctx_n.slot = slot_next;
                    ctx_n.pos  = pos_next;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase      <= PH_SEARCH;
            ctx        <= '0;
            shreg      <= '0;
            pairs      <= '0;
            frame_done <= 1'b0;
        end else begin
            phase      <= phase_n;
            ctx        <= ctx_n;
            shreg      <= shreg_n;
            pairs      <= pairs_n;
            frame_done <= done_n;
        end
    end

    assign synced    = (phase == PH_OPEN) || (phase == PH_DATA);
    assign wide_mode = ctx.wide;

endmodule

// File: rtl/ppd_cmd_decoder_chk.sv
module ppd_cmd_decoder_chk #(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       restart,
    input logic                       synced,
    input logic                       frame_done,
    input logic [$clog2(DEPTH+1)-1:0] byte_count,
    input logic [DEPTH-1:0]           parity_bits,
    input logic                       overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7
    done_parked_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !synced);

    // R7
    done_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_done) |-> $past(synced));

    // R10
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        byte_count <= CNT_W'(DEPTH));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> byte_count == CNT_W'(DEPTH));

    // R11
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!synced && byte_count == '0 && !overflow && parity_bits == '0));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        byte_count != $past(byte_count) |->
            (byte_count == $past(byte_count) + 1'b1 || byte_count == '0));

    // R9
    parity_shift_chk: assert property (@(posedge clk) disable iff (rst)
        byte_count == $past(byte_count) + 1'b1 |->
            parity_bits[DEPTH-1:1] == $past(parity_bits[DEPTH-2:0]));

endmodule

bind ppd_cmd_decoder ppd_cmd_decoder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .synced      (synced),
    .frame_done  (frame_done),
    .byte_count  (byte_count),
    .parity_bits (parity_bits),
    .overflow    (overflow)
);

// File: tb/ppd_cmd_decoder_test.sv
module ppd_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_win = 4'hF;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        synced, wide_mode, frame_done, overflow;
    logic [5:0]  byte_count;
    logic [31:0] parity_bits;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int done_seen = 0;

    always #4 clk = ~clk;

    ppd_cmd_decoder uut (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_win(in_win), .rd_addr(rd_addr), .rd_data(rd_data),
        .synced(synced), .wide_mode(wide_mode), .frame_done(frame_done),
        .byte_count(byte_count), .parity_bits(parity_bits), .overflow(overflow)
    );

    // ---------------- behavioural reference model ----------------
    int          m_ph;      // 0 search, 1 opening group, 2 data, 3 parked
    int          m_idle, m_lane, m_slot, m_pos, m_sh, m_pairs, m_glen;
    bit          m_second, m_wide, m_ovf, m_done, m_drop;
    byte unsigned m_q[$];
    logic [31:0] m_par;

    function automatic void m_store(input int b);
        logic [7:0] v;
        v = b[7:0];
        if (m_q.size() >= 32) m_ovf = 1'b1;
        else begin
            m_q.push_back(v);
            m_par = {m_par[30:0], ~^v};
        end
    endfunction

    always @(posedge clk) begin
        m_done = 1'b0;
        if (rst || restart) begin
            m_ph = 0; m_idle = 0; m_lane = 0; m_slot = 0; m_pos = 0;
            m_sh = 0; m_pairs = 0; m_second = 0; m_wide = 0; m_ovf = 0;
            m_q.delete(); m_par = '0;
        end else if (in_valid) begin
            if (m_ph == 0) begin
                if (in_win == 4'hF) begin
                    if (m_idle < 8) m_idle++;
                end else if (m_idle == 8) begin
                    for (int i = 3; i >= 0; i--) if (!in_win[i]) begin m_lane = i; break; end
                    m_ph = 1; m_second = 1; m_slot = 0; m_pos = 0; m_wide = 0;
                    m_sh = 0; m_pairs = 0; m_q.delete(); m_par = '0; m_ovf = 0; m_idle = 0;
                end else m_idle = 0;
            end else if (m_ph != 3) begin
                m_drop = !in_win[m_lane];
                if (!m_second) begin
                    m_second = 1;
                    if (m_drop && m_ph == 2) begin
                        if (m_slot != 0) m_ph = 0;
                        else if (m_q.size() > 0) begin m_ph = 3; m_done = 1; end
                        else begin m_store(240); m_ph = 0; end
                    end
                end else begin
                    m_second = 0;
                    m_slot++;
                    if (m_drop) begin
                        if (m_pos != 0) m_ph = 0;
                        else m_pos = m_slot;
                    end
                    m_glen = (m_ph == 2 && m_wide) ? 256 : 4;
                    if (m_ph != 0 && m_slot == m_glen) begin
                        if (m_ph == 1) begin
                            if (m_pos == 4) begin m_ph = 2; m_wide = 1; end
                            else if (m_pos == 3) begin m_ph = 2; m_wide = 0; end
                            else m_ph = 0;
                        end else if (m_pos == 0) m_ph = 0;
                        else if (m_wide) m_store(m_pos - 1);
                        else begin
                            m_sh = (m_sh >> 2) | ((m_pos - 1) << 6);
                            m_pairs++;
                            if (m_pairs == 4) begin m_store(m_sh); m_sh = 0; m_pairs = 0; end
                        end
                        m_slot = 0; m_pos = 0;
                    end
                end
            end
        end
    end

    task automatic expect_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            expect_eq("R3", "synced", synced, (m_ph == 1 || m_ph == 2));
            expect_eq("R3", "wide_mode", wide_mode, m_wide);
            expect_eq("R7", "frame_done", frame_done, m_done);
            expect_eq("R4", "byte_count", byte_count, m_q.size());
            expect_eq("R9", "parity_bits", parity_bits, m_par);
            expect_eq("R10", "overflow", overflow, m_ovf);
            if (frame_done) done_seen++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic [3:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_win   = w;
    endtask

    task automatic quiet();
        @(negedge clk);
        in_valid = 1'b0;
        in_win   = 4'hF;
        #1;
    endtask

    task automatic highs(input int n);
        repeat (n) drive(4'hF);
    endtask

    task automatic slot(input bit dropped, input logic [3:0] dw);
        drive(4'hF);
        drive(dropped ? dw : 4'hF);
    endtask

    task automatic open_frame(input bit wide, input logic [3:0] sw, input logic [3:0] dw);
        drive(sw);
        drive(4'hF);
        slot(1'b0, dw);
        slot(!wide, dw);
        slot(wide, dw);
    endtask

    task automatic send_pairs(input int b, input logic [3:0] dw);
        for (int k = 0; k < 4; k++) begin
            for (int s = 1; s <= 4; s++) slot(s == ((b >> (2 * k)) & 3) + 1, dw);
        end
    endtask

    task automatic send_wide(input int b, input logic [3:0] dw);
        for (int s = 1; s <= 256; s++) slot(s == b + 1, dw);
    endtask

    task automatic peek(input int addr, input int exp, input string req);
        @(negedge clk);
        rd_addr = addr[4:0];
        #1;
        expect_eq(req, "rd_data", rd_data, exp);
    endtask

    task automatic pulse_restart(input logic [3:0] w);
        @(negedge clk);
        restart  = 1'b1;
        in_valid = 1'b1;
        in_win   = w;
        @(negedge clk);
        restart  = 1'b0;
        in_valid = 1'b0;
        in_win   = 4'hF;
        #1;
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        quiet();
        // R12 reset state
        expect_eq("R12", "synced", synced, 0);
        expect_eq("R12", "frame_done", frame_done, 0);
        expect_eq("R12", "byte_count", byte_count, 0);
        expect_eq("R12", "overflow", overflow, 0);
        expect_eq("R12", "parity_bits", parity_bits, 0);
        expect_eq("R12", "wide_mode", wide_mode, 0);

        // R1 too short an idle run
        highs(7); drive(4'h0); quiet();
        expect_eq("R1", "synced after 7 highs", synced, 0);

        // R4 / R9 / R7 two-bit frame
        highs(8); open_frame(1'b0, 4'h0, 4'h0);
        quiet();
        expect_eq("R1", "synced after 8 highs", synced, 1);
        expect_eq("R3", "wide_mode", wide_mode, 0);
        send_pairs(8'hA5, 4'h0); send_pairs(8'h07, 4'h0);
        drive(4'h0); quiet(); quiet();
        expect_eq("R4", "byte_count", byte_count, 2);
        expect_eq("R9", "parity_bits", parity_bits, 32'h2);
        expect_eq("R7", "frame reports", done_seen, 1);
        peek(0, 8'hA5, "R4"); peek(1, 8'h07, "R4");
        // R7 parked: input ignored
        highs(10); drive(4'h0); slot(1'b1, 4'h0); quiet();
        expect_eq("R7", "parked synced", synced, 0);
        expect_eq("R7", "parked byte_count", byte_count, 2);
        expect_eq("R7", "parked reports", done_seen, 1);

        // R11 restart clears; simultaneous qualified drop window discarded
        pulse_restart(4'hF);
        expect_eq("R11", "byte_count", byte_count, 0);
        highs(8); pulse_restart(4'h0);
        expect_eq("R11", "synced with same-cycle window", synced, 0);
        drive(4'h0); quiet();
        expect_eq("R11", "high count cleared", synced, 0);

        // R2 lane lock on earliest drop
        highs(8); open_frame(1'b0, 4'b1100, 4'b1101);
        send_pairs(8'h5A, 4'b1101);
        drive(4'b1101); quiet(); quiet();
        expect_eq("R2", "reports", done_seen, 2);
        expect_eq("R2", "byte_count", byte_count, 1);
        peek(0, 8'h5A, "R2");
        pulse_restart(4'hF);

        // R5 byte mode
        highs(8); open_frame(1'b1, 4'h0, 4'h0);
        quiet();
        expect_eq("R3", "wide_mode", wide_mode, 1);
        send_wide(0, 4'h0); send_wide(255, 4'h0); send_wide(128, 4'h0);
        drive(4'h0); quiet(); quiet();
        expect_eq("R5", "byte_count", byte_count, 3);
        expect_eq("R9", "parity_bits", parity_bits, 32'h6);
        peek(0, 8'h00, "R5"); peek(1, 8'hFF, "R5"); peek(2, 8'h80, "R5");
        pulse_restart(4'hF);

        // R3 bad opening position
        highs(8); drive(4'h0); drive(4'hF); slot(1'b1, 4'h0); slot(1'b0, 4'h0); slot(1'b0, 4'h0);
        quiet();
        expect_eq("R3", "synced on position 2", synced, 0);

        // R6 error paths
        d0 = done_seen;
        highs(8); open_frame(1'b0, 4'h0, 4'h0); slot(1'b1, 4'h0); slot(1'b1, 4'h0); quiet();
        expect_eq("R6", "double drop", synced, 0);
        highs(8); open_frame(1'b0, 4'h0, 4'h0);
        for (int s = 0; s < 4; s++) slot(1'b0, 4'h0);
        quiet();
        expect_eq("R6", "empty group", synced, 0);
        highs(8); open_frame(1'b0, 4'h0, 4'h0); slot(1'b1, 4'h0); drive(4'h0); quiet();
        expect_eq("R6", "mid-group first-half drop", synced, 0);
        expect_eq("R6", "no report", done_seen, d0);

        // R8 empty frame
        highs(8); open_frame(1'b0, 4'h0, 4'h0); drive(4'h0); quiet(); quiet();
        expect_eq("R8", "synced", synced, 0);
        expect_eq("R8", "byte_count", byte_count, 1);
        expect_eq("R8", "parity_bits", parity_bits, 32'h1);
        expect_eq("R8", "no report", done_seen, d0);
        peek(0, 8'hF0, "R8");

        // R10 overflow
        highs(8); open_frame(1'b0, 4'h0, 4'h0);
        for (int i = 0; i < 33; i++) send_pairs((i * 7 + 1) & 8'hFF, 4'h0);
        drive(4'h0); quiet(); quiet();
        expect_eq("R10", "byte_count", byte_count, 32);
        expect_eq("R10", "overflow", overflow, 1);
        expect_eq("R10", "reports", done_seen, d0 + 1);
        peek(31, (31 * 7 + 1) & 8'hFF, "R10");
        peek(0, 1, "R10");
        pulse_restart(4'hF);
        expect_eq("R11", "overflow cleared", overflow, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule